// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This unit sits beside the fetch stage of a small 32-bit core and decides, in each cycle, whether an exception request becomes an interrupt. The core presents four request sources: program faults, system calls, the decrementer and the external input. Alongside them it supplies the current and next instruction addresses, its machine state word, a timer interrupt enable, the vector prefix and the per-cause vector offsets. The unit picks at most one cause. For that cause it forms the handler address and saves the resume address and the old state word. It also produces the reduced state word for handler entry and, for program faults only, a new syndrome word.

All of these results are registered. They appear together with a one-cycle redirect strobe in the cycle after the request is sampled. The unit also keeps the decrementer status flag. A counter underflow pulse sets the flag, and only a software write-one-to-clear pulse clears it.

Top module: `exc_entry_unit`

## Requirements
- R1: While rst_ni is low, every output is zero, including the decrementer status flag.
- R2: Causes are ranked program (highest), then system call, then decrementer, then external input. Only the highest ranked cause that is eligible is serviced in a cycle.
- R3: The handler address is msr-independent. It is formed from bits [31:16] of vpfx_i, then bits [15:4] of the chosen cause's offset input, then 4'b0000. The offset inputs are voff_prg_i, voff_sc_i, voff_dec_i and voff_ext_i.
- R4: On entry, srr1_o holds the value of msr_i in the sampling cycle.
- R5: On entry, msr_o keeps bits 17, 12 and 9 of msr_i and clears every other bit.
- R6: The saved resume address in srr0_o depends on the cause. A program fault saves pc_i. A system call saves pc_i + 4. A decrementer or external interrupt saves npc_i.
- R7: The decrementer is eligible only when three conditions hold together: the status flag is set before the edge, tmr_die_i is 1 and msr_i bit 15 is 1.
- R8: The external input is eligible only when msr_i bit 15 is 1. Program faults and system calls ignore that bit.
- R9: On a program fault, esr_o is loaded with exactly one set bit and all other bits clear. Bit 27 marks an illegal instruction, bit 26 a privileged instruction and bit 25 a trap, ranked in that order when several are raised. Other causes leave esr_o unchanged.
- R10: dec_evt_i sets dis_o at the next edge. dis_o then stays set until a dec_clr_i pulse. A set and a clear in the same cycle leave the flag set, and taking the decrementer interrupt does not clear it.
- R11: redir_vld_o is high for exactly the cycle after an eligible request. When nothing is eligible, redir_vld_o is low and redir_pc_o, srr0_o, srr1_o, msr_o and esr_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| npc_i | input | 32 | Address of the next instruction to execute |
| msr_i | input | 32 | Current machine state word |
| tmr_die_i | input | 1 | Decrementer interrupt enable |
| dec_evt_i | input | 1 | Decrementer underflow pulse, sets the status flag |
| dec_clr_i | input | 1 | Write-one-to-clear pulse for the status flag |
| vpfx_i | input | 32 | Vector prefix register |
| voff_prg_i | input | 32 | Program fault vector offset |
| voff_sc_i | input | 32 | System call vector offset |
| voff_dec_i | input | 32 | Decrementer vector offset |
| voff_ext_i | input | 32 | External input vector offset |
| prg_ill_i | input | 1 | Illegal instruction fault |
| prg_priv_i | input | 1 | Privileged instruction fault |
| prg_trap_i | input | 1 | Trap fault |
| sc_i | input | 1 | System call request |
| ext_i | input | 1 | External input request |
| redir_vld_o | output | 1 | Redirect strobe, one cycle |
| redir_pc_o | output | 32 | Handler fetch address |
| srr0_o | output | 32 | Saved resume address |
| srr1_o | output | 32 | Saved machine state |
| msr_o | output | 32 | Machine state for handler entry |
| esr_o | output | 32 | Syndrome word |
| dis_o | output | 1 | Decrementer status flag |

## Verification
The hardest case to reach is a decrementer take in the same cycle that software clears the status flag. The outcome depends on the flag value before the edge, and that value can only be set up through an earlier underflow pulse. The stimulus first raises dec_evt_i with the enable low, so the flag is set and nothing is taken. It then applies a set and a clear together to show that set wins. Finally it drives a lone clear together with an open enable and bit 15 set, and expects one decrementer entry followed by a cleared flag. A further cycle shows that the same enable no longer leads to an entry once the flag is clear.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NCAUSE = 4;
  localparam int unsigned PFX_LO = 16;   // prefix occupies [XLEN-1:PFX_LO]
  localparam int unsigned OFF_LO = 4;    // offset occupies [PFX_LO-1:OFF_LO]
  localparam int unsigned INSN_B = 4;

  localparam int unsigned MSR_CE = 17;
  localparam int unsigned MSR_EE = 15;
  localparam int unsigned MSR_ME = 12;
  localparam int unsigned MSR_DE = 9;

  localparam int unsigned ESR_PIL = 27;
  localparam int unsigned ESR_PPR = 26;
  localparam int unsigned ESR_PTR = 25;

  // index is priority: lower wins
  typedef enum logic [1:0] {
    CAUSE_PRG = 2'd0,
    CAUSE_SC  = 2'd1,
    CAUSE_DEC = 2'd2,
    CAUSE_EXT = 2'd3
  } cause_e;

  localparam logic [XLEN-1:0] MSR_KEEP =
    (XLEN'(1) << MSR_CE) | (XLEN'(1) << MSR_ME) | (XLEN'(1) << MSR_DE);
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
  parameter int unsigned N      = 4,
  parameter int unsigned XLEN   = 32,
  parameter int unsigned PFX_LO = 16,
  parameter int unsigned OFF_LO = 4
) (
  input  logic [XLEN-1:0]        pfx_i,
  input  logic [N-1:0][XLEN-1:0] off_i,
  input  logic [N-1:0]           gnt_i,
  output logic [XLEN-1:0]        vec_o
);
  localparam int unsigned OFF_W = PFX_LO - OFF_LO;

  logic [N-1:0][OFF_W-1:0] fld;

  for (genvar g = 0; g < N; g++) begin : g_fld
    assign fld[g] = gnt_i[g] ? off_i[g][PFX_LO-1:OFF_LO] : '0;
  end

  always_comb begin
    logic [OFF_W-1:0] sel;
    sel = '0;
    for (int i = 0; i < N; i++) sel |= fld[i];
    vec_o = {pfx_i[XLEN-1:PFX_LO], sel, {OFF_LO{1'b0}}};
  end
endmodule

// File: rtl/exc_dis_flag.sv
module exc_dis_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic            tmr_die_i,
  input  logic            dec_evt_i,
  input  logic            dec_clr_i,
  input  logic [XLEN-1:0] vpfx_i,
  input  logic [XLEN-1:0] voff_prg_i,
  input  logic [XLEN-1:0] voff_sc_i,
  input  logic [XLEN-1:0] voff_dec_i,
  input  logic [XLEN-1:0] voff_ext_i,
  input  logic            prg_ill_i,
  input  logic            prg_priv_i,
  input  logic            prg_trap_i,
  input  logic            sc_i,
  input  logic            ext_i,
  output logic            redir_vld_o,
  output logic [XLEN-1:0] redir_pc_o,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] esr_o,
  output logic            dis_o
);
  logic                     dis_q;
  logic                     ee;
  logic [NCAUSE-1:0]        req, gnt;
  logic                     take;
  logic [NCAUSE-1:0][XLEN-1:0] off, ret;
  logic [XLEN-1:0]          vec, ret_sel, esr_nxt;

  exc_dis_flag u_dis (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dec_evt_i),
    .clr_i  (dec_clr_i),
    .flag_o (dis_q)
  );

  assign ee = msr_i[MSR_EE];

  always_comb begin
    req            = '0;
    req[CAUSE_PRG] = prg_ill_i | prg_priv_i | prg_trap_i;
    req[CAUSE_SC]  = sc_i;
    req[CAUSE_DEC] = dis_q & tmr_die_i & ee;
    req[CAUSE_EXT] = ext_i & ee;
  end

  exc_prio_sel #(.N(NCAUSE)) u_prio (
    .req_i (req),
    .gnt_o (gnt),
    .any_o (take)
  );

  always_comb begin
    off            = '0;
    off[CAUSE_PRG] = voff_prg_i;
    off[CAUSE_SC]  = voff_sc_i;
    off[CAUSE_DEC] = voff_dec_i;
    off[CAUSE_EXT] = voff_ext_i;
    ret            = '0;
    ret[CAUSE_PRG] = pc_i;
    ret[CAUSE_SC]  = pc_i + XLEN'(INSN_B);
    ret[CAUSE_DEC] = npc_i;
    ret[CAUSE_EXT] = npc_i;
  end

  exc_vec_gen #(
    .N      (NCAUSE),
    .XLEN   (XLEN),
    .PFX_LO (PFX_LO),
    .OFF_LO (OFF_LO)
  ) u_vec (
    .pfx_i (vpfx_i),
    .off_i (off),
    .gnt_i (gnt),
    .vec_o (vec)
  );

  always_comb begin
    ret_sel = '0;
    for (int i = 0; i < NCAUSE; i++)
      if (gnt[i]) ret_sel |= ret[i];
  end

  always_comb begin
    esr_nxt = '0;
    if (prg_ill_i)       esr_nxt[ESR_PIL] = 1'b1;
    else if (prg_priv_i) esr_nxt[ESR_PPR] = 1'b1;
    else                 esr_nxt[ESR_PTR] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_vld_o <= 1'b0;
      redir_pc_o  <= '0;
      srr0_o      <= '0;
      srr1_o      <= '0;
      msr_o       <= '0;
      esr_o       <= '0;
    end else begin
      redir_vld_o <= take;
      if (take) begin
        redir_pc_o <= vec;
        srr0_o     <= ret_sel;
        srr1_o     <= msr_i;
        msr_o      <= msr_i & MSR_KEEP;
        if (gnt[CAUSE_PRG]) esr_o <= esr_nxt;
      end
    end
  end

  assign dis_o = dis_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] msr_i,
  input logic            tmr_die_i,
  input logic            dec_clr_i,
  input logic            prg_ill_i,
  input logic            prg_priv_i,
  input logic            prg_trap_i,
  input logic            sc_i,
  input logic            ext_i,
  input logic            redir_vld_o,
  input logic [XLEN-1:0] redir_pc_o,
  input logic [XLEN-1:0] srr1_o,
  input logic [XLEN-1:0] msr_o,
  input logic [XLEN-1:0] esr_o,
  input logic            dis_o
);
  localparam logic [XLEN-1:0] ESR_MASK =
    (XLEN'(1) << ESR_PIL) | (XLEN'(1) << ESR_PPR) | (XLEN'(1) << ESR_PTR);

  logic prg_any;
  assign prg_any = prg_ill_i | prg_priv_i | prg_trap_i;

  p_vec_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_vld_o |-> (redir_pc_o[OFF_LO-1:0] == '0));

  p_srr1_saved_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_vld_o |-> (srr1_o == $past(msr_i)));

  p_msr_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_vld_o |-> ((msr_o & ~MSR_KEEP) == '0));

  p_ext_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prg_any && !sc_i && !msr_i[MSR_EE]) |=> !redir_vld_o);

  p_esr_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_any |=> (redir_vld_o && $onehot(esr_o) && ((esr_o & ~ESR_MASK) == '0)));

  p_dis_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_o && !dec_clr_i) |=> dis_o);

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prg_any && !sc_i && !ext_i && !(dis_o && tmr_die_i)) |=>
      (!redir_vld_o && $stable(redir_pc_o) && $stable(esr_o)));

  p_prg_beats_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prg_any && (sc_i || ext_i)) |=> $stable(1'b1) && redir_vld_o && (esr_o != '0));
endmodule

bind exc_entry_unit exc_entry_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msr_i       (msr_i),
  .tmr_die_i   (tmr_die_i),
  .dec_clr_i   (dec_clr_i),
  .prg_ill_i   (prg_ill_i),
  .prg_priv_i  (prg_priv_i),
  .prg_trap_i  (prg_trap_i),
  .sc_i        (sc_i),
  .ext_i       (ext_i),
  .redir_vld_o (redir_vld_o),
  .redir_pc_o  (redir_pc_o),
  .srr1_o      (srr1_o),
  .msr_o       (msr_o),
  .esr_o       (esr_o),
  .dis_o       (dis_o)
);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] VPFX     = 32'hFFF0_1234;
  localparam logic [31:0] VOFF_PRG = 32'hABCD_0607;
  localparam logic [31:0] VOFF_SC  = 32'h1234_080F;
  localparam logic [31:0] VOFF_DEC = 32'h0000_0A05;
  localparam logic [31:0] VOFF_EXT = 32'hFFFF_0401;
  localparam logic [31:0] KEEP     = 32'h0002_1200; // bits 17,12,9

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0, npc_i = '0, msr_i = '0;
  logic        tmr_die_i = 0, dec_evt_i = 0, dec_clr_i = 0;
  logic        prg_ill_i = 0, prg_priv_i = 0, prg_trap_i = 0, sc_i = 0, ext_i = 0;
  logic        redir_vld_o, dis_o;
  logic [31:0] redir_pc_o, srr0_o, srr1_o, msr_o, esr_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc_i), .npc_i(npc_i), .msr_i(msr_i),
    .tmr_die_i(tmr_die_i), .dec_evt_i(dec_evt_i), .dec_clr_i(dec_clr_i),
    .vpfx_i(VPFX), .voff_prg_i(VOFF_PRG), .voff_sc_i(VOFF_SC),
    .voff_dec_i(VOFF_DEC), .voff_ext_i(VOFF_EXT),
    .prg_ill_i(prg_ill_i), .prg_priv_i(prg_priv_i), .prg_trap_i(prg_trap_i),
    .sc_i(sc_i), .ext_i(ext_i),
    .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o), .srr0_o(srr0_o),
    .srr1_o(srr1_o), .msr_o(msr_o), .esr_o(esr_o), .dis_o(dis_o)
  );

  typedef struct {
    string       tag;
    logic        vld;
    logic [31:0] pc, srr0, srr1, msr, esr;
    logic        dis;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [31:0] m_pc = '0, m_srr0 = '0, m_srr1 = '0, m_msr = '0, m_esr = '0;
  logic        m_dis = 1'b0;

  task automatic drive(input string tag,
                       input logic ill, input logic priv, input logic trap,
                       input logic sc, input logic ext, input logic die,
                       input logic evt, input logic clr,
                       input logic [31:0] msr, input logic [31:0] pc,
                       input logic [31:0] npc);
    exp_t e;
    logic ee, prg, dreq, ereq;
    logic [31:0] off;
    @(negedge clk);
    prg_ill_i = ill; prg_priv_i = priv; prg_trap_i = trap;
    sc_i = sc; ext_i = ext; tmr_die_i = die; dec_evt_i = evt; dec_clr_i = clr;
    msr_i = msr; pc_i = pc; npc_i = npc;
    ee   = msr[15];
    prg  = ill | priv | trap;
    dreq = m_dis & die & ee;
    ereq = ext & ee;
    e.tag = tag;
    e.vld = prg | sc | dreq | ereq;
    off = '0;
    if (e.vld) begin
      if (prg) begin
        off = VOFF_PRG; m_srr0 = pc;
        m_esr = ill ? 32'h0800_0000 : priv ? 32'h0400_0000 : 32'h0200_0000;
      end else if (sc) begin
        off = VOFF_SC; m_srr0 = pc + 32'd4;
      end else if (dreq) begin
        off = VOFF_DEC; m_srr0 = npc;
      end else begin
        off = VOFF_EXT; m_srr0 = npc;
      end
      m_pc   = {VPFX[31:16], off[15:4], 4'b0000};
      m_srr1 = msr;
      m_msr  = msr & KEEP;
    end
    m_dis = evt | (m_dis & ~clr);
    e.pc = m_pc; e.srr0 = m_srr0; e.srr1 = m_srr1;
    e.msr = m_msr; e.esr = m_esr; e.dis = m_dis;
    q.push_back(e);
  endtask

  // monitor: the item queued before this edge is what the edge produces
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        #2;
        checks++;
        if (redir_vld_o !== e.vld || redir_pc_o !== e.pc || srr0_o !== e.srr0 ||
            srr1_o !== e.srr1 || msr_o !== e.msr || esr_o !== e.esr || dis_o !== e.dis) begin
          errors++;
          $display("FAIL %s: got vld=%0b pc=%h srr0=%h srr1=%h msr=%h esr=%h dis=%0b exp vld=%0b pc=%h srr0=%h srr1=%h msr=%h esr=%h dis=%0b",
                   e.tag, redir_vld_o, redir_pc_o, srr0_o, srr1_o, msr_o, esr_o, dis_o,
                   e.vld, e.pc, e.srr0, e.srr1, e.msr, e.esr, e.dis);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got running exp finished");
    finish_run();
  end

  initial begin
    #3;
    // R1 reset state
    checks++;
    if (redir_vld_o !== 0 || redir_pc_o !== 0 || srr0_o !== 0 || srr1_o !== 0 ||
        msr_o !== 0 || esr_o !== 0 || dis_o !== 0) begin
      errors++;
      $display("FAIL R1: got vld=%0b pc=%h esr=%h dis=%0b exp all zero",
               redir_vld_o, redir_pc_o, esr_o, dis_o);
    end
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    drive("R11 idle",           0,0,0, 0,0,0, 0,0, 32'hFFFF_FFFF, 32'h100, 32'h200);
    drive("R3 R4 R5 R6 sc",     0,0,0, 1,0,0, 0,0, 32'hFFFF_FFFF, 32'h1000, 32'h2000);
    drive("R2 R9 prg ill",      1,1,1, 1,1,0, 0,0, 32'h0000_8000, 32'h1100, 32'h1104);
    drive("R9 prg priv",        0,1,1, 0,0,0, 0,0, 32'h0002_0000, 32'h1200, 32'h1300);
    drive("R9 prg trap",        0,0,1, 0,0,0, 0,0, 32'h0000_0000, 32'h1400, 32'h1404);
    drive("R8 ext masked",      0,0,0, 0,1,0, 0,0, 32'hFFFF_7FFF, 32'h1500, 32'h1600);
    drive("R8 R6 ext taken",    0,0,0, 0,1,0, 0,0, 32'h0000_9200, 32'h1700, 32'h1800);
    drive("R10 dec set",        0,0,0, 0,0,0, 1,0, 32'h0000_8000, 32'h1900, 32'h1A00);
    drive("R7 dec ee low",      0,0,0, 0,0,1, 0,0, 32'hFFFF_7FFF, 32'h1B00, 32'h1C00);
    drive("R2 R7 R9 dec wins",  0,0,0, 0,1,1, 0,0, 32'h0000_F000, 32'h1D00, 32'h1E00);
    drive("R10 set over clr",   0,0,0, 0,0,0, 1,1, 32'h0000_8000, 32'h1F00, 32'h2000);
    drive("R7 R10 take on clr", 0,0,0, 0,0,1, 0,1, 32'h0000_8200, 32'h2100, 32'h2200);
    drive("R7 dec flag clear",  0,0,0, 0,0,1, 0,0, 32'h0000_8000, 32'h2300, 32'h2400);
    drive("R2 sc over ext",     0,0,0, 1,1,0, 0,0, 32'h0000_8000, 32'h2500, 32'h2600);
    drive("R11 idle tail",      0,0,0, 0,0,0, 0,0, 32'h0000_0000, 32'h2700, 32'h2800);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule